// File: doc/BRIEF.md
# Saturating Dual-Halfword Add/Subtract Execute Unit

This block is a single-cycle execute stage for packed signed 16-bit arithmetic. On every clock it takes an instruction word, the two source operand values already read from the register file, and the current N, Z, C and V flags. From these it produces the destination register index, a 32-bit result and a write-enable. The two 16-bit lanes of the operands are combined in one of four ways: both added, both subtracted, or one of two crossed forms. In a crossed form the low lane of the first operand meets the high lane of the second, and the high lane of the first operand meets the low lane of the second.

Each lane is computed one bit wider than its width and then clamped to the signed 16-bit range. It never wraps. The write-enable depends on the 4-bit condition field tested against the flags. Encodings outside the supported group raise an undefined-operation output and suppress the write. The source register indices are decoded combinationally so that a register file can be addressed in the same cycle. The outputs are registered and appear one clock after the instruction is presented.

Top module: `dhsat_unit`

## Requirements
- R1: Selector bits 7:5 = 0 give low lane = N.lo + M.lo and high lane = N.hi + M.hi, where N is `opN`, M is `opM`, lo is bits 15:0 and hi is bits 31:16, each taken as signed.
- R2: Selector 1 gives low lane = N.lo − M.hi and high lane = N.hi + M.lo.
- R3: Selector 2 gives low lane = N.lo + M.hi and high lane = N.hi − M.lo.
- R4: Selector 3 gives low lane = N.lo − M.lo and high lane = N.hi − M.hi.
- R5: Each lane saturates on its own. A true sum above 32767 yields 0x7FFF, and a true sum below −32768 yields 0x8000.
- R6: `result` carries the low lane in bits 15:0 and the high lane in bits 31:16.
- R7: The condition field is bits 31:28 and the flags port is {N,Z,C,V} in bits 3..0. Codes 0/1 test Z set/clear, 2/3 test C set/clear, 4/5 test N set/clear and 6/7 test V set/clear. Code 8 passes when C=1 and Z=0, and code 9 is its inverse. Code 10 passes when N==V, and code 11 is its inverse. Code 12 passes when Z=0 and N==V, and code 13 is its inverse. Code 14 always passes and code 15 never passes.
- R8: On a legal encoding whose condition fails, `wrEn` and `undefOp` are both 0.
- R9: An encoding is legal only when bits 27:20 = 0x62, bits 11:8 = 0xF, bit 4 = 1 and the selector is 0..3. Any other encoding drives `undefOp` to 1 and `wrEn` to 0, whatever the condition.
- R10: `dstIdx` equals instruction bits 15:12. `result`, `wrEn`, `undefOp` and `dstIdx` all reflect the inputs sampled at the previous rising clock edge.
- R11: While `rst` is high, all registered outputs are 0.
- R12: `srcNIdx` equals instruction bits 19:16 and `srcMIdx` equals bits 3:0, both combinationally in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 32 | Instruction word |
| opN | input | 32 | First source operand value |
| opM | input | 32 | Second source operand value |
| flags | input | 4 | Condition flags {N,Z,C,V} |
| srcNIdx | output | 4 | First source register index |
| srcMIdx | output | 4 | Second source register index |
| dstIdx | output | 4 | Destination register index (registered) |
| result | output | 32 | Packed saturated result (registered) |
| wrEn | output | 1 | Register write enable (registered) |
| undefOp | output | 1 | Unsupported encoding seen (registered) |

## Verification
Several properties are checked on every cycle. A write and an undefined flag never occur together. The destination index tracks the instruction one cycle later. An always-code legal instruction writes, and a never-code instruction does not. Any selector from 4 to 7 is flagged. Subtracting an operand from itself gives zero. The arithmetic of each selector, the exact clamp values at both ends, and the independence of the two lanes can only be shown by the bench. It sweeps boundary halfword values through every selector and compares each result with an arithmetic model. Only the bench's sweep can show the full table of the sixteen condition codes against all sixteen flag patterns.

// File: rtl/dhsat_pkg.sv
`timescale 1ns/1ps
package dhsat_pkg;

  // Fixed encoding bits that identify the saturating packed-halfword group
  localparam logic [7:0] GROUP_TAG = 8'h62;
  localparam logic [3:0] SBO_NIB   = 4'hF;

  // Strobes handed from control to datapath
  typedef struct packed {
    logic crossM;  // lanes of the second operand are exchanged
    logic subLo;   // low lane subtracts
    logic subHi;   // high lane subtracts
  } laneCtrl_t;

  // Condition test; nzcv = {N,Z,C,V}
  function automatic logic condHolds(input logic [3:0] cc, input logic [3:0] nzcv);
    logic n, z, c, v, base;
    n = nzcv[3];
    z = nzcv[2];
    c = nzcv[1];
    v = nzcv[0];
    unique case (cc[3:1])
      3'd0:    base = z;
      3'd1:    base = c;
      3'd2:    base = n;
      3'd3:    base = v;
      3'd4:    base = c & ~z;
      3'd5:    base = (n == v);
      3'd6:    base = ~z & (n == v);
      default: base = 1'b1;
    endcase
    if (cc == 4'hF)      return 1'b0;
    else if (cc == 4'hE) return 1'b1;
    else                 return cc[0] ? ~base : base;
  endfunction

endpackage

// File: rtl/dhsat_lane.sv
`timescale 1ns/1ps
module dhsat_lane #(
  parameter int LANE_W = 16
) (
  input  logic [LANE_W-1:0] laneA,
  input  logic [LANE_W-1:0] laneB,
  input  logic              doSub,
  output logic [LANE_W-1:0] laneY
);
  localparam int EXT_W = LANE_W + 1;
  localparam logic [LANE_W-1:0] MAX_POS = {1'b0, {(LANE_W-1){1'b1}}};
  localparam logic [LANE_W-1:0] MIN_NEG = {1'b1, {(LANE_W-1){1'b0}}};

  logic [EXT_W-1:0] extA, extB, extSum;

  always_comb begin
    extA   = {laneA[LANE_W-1], laneA};
    extB   = {laneB[LANE_W-1], laneB};
    extSum = doSub ? (extA - extB) : (extA + extB);
    if (extSum[EXT_W-1] != extSum[EXT_W-2])
      laneY = extSum[EXT_W-1] ? MIN_NEG : MAX_POS;
    else
      laneY = extSum[LANE_W-1:0];
  end
endmodule

// File: rtl/dhsat_ctrl.sv
`timescale 1ns/1ps
module dhsat_ctrl
  import dhsat_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] instr,
  input  logic [3:0]         flags,
  output laneCtrl_t          strobes,
  output logic [IDX_W-1:0]   srcNIdx,
  output logic [IDX_W-1:0]   srcMIdx,
  output logic [IDX_W-1:0]   dstIdx,
  output logic               wrEn,
  output logic               undefOp
);
  logic [3:0] condCode;
  logic [2:0] selCode;
  logic       groupOk, legal, passes;

  always_comb begin
    condCode = instr[31:28];
    selCode  = instr[7:5];
    srcNIdx  = instr[19:16];
    srcMIdx  = instr[3:0];
    groupOk  = (instr[27:20] == GROUP_TAG) && (instr[11:8] == SBO_NIB) && instr[4];
    legal    = groupOk && !selCode[2];
    passes   = condHolds(condCode, flags);
    // selector: 0 add/add, 1 sub/add crossed, 2 add/sub crossed, 3 sub/sub
    strobes.crossM = selCode[0] ^ selCode[1];
    strobes.subLo  = selCode[0];
    strobes.subHi  = selCode[1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dstIdx  <= '0;
      wrEn    <= 1'b0;
      undefOp <= 1'b0;
    end else begin
      dstIdx  <= instr[15:12];
      wrEn    <= legal && passes;
      undefOp <= !legal;
    end
  end
endmodule

// File: rtl/dhsat_datapath.sv
`timescale 1ns/1ps
module dhsat_datapath
  import dhsat_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] opN,
  input  logic [DATA_W-1:0] opM,
  input  laneCtrl_t         strobes,
  output logic [DATA_W-1:0] result
);
  localparam int LANES  = 2;
  localparam int LANE_W = DATA_W / LANES;

  logic [LANE_W-1:0] nLane   [LANES];
  logic [LANE_W-1:0] mLane   [LANES];
  logic [LANE_W-1:0] outLane [LANES];
  logic [DATA_W-1:0] packedNext;

  for (genvar li = 0; li < LANES; li++) begin : g_lane
    localparam int OTHER = LANES - 1 - li;
    logic [LANE_W-1:0] mSel;
    logic              laneSub;

    assign nLane[li] = opN[li*LANE_W +: LANE_W];
    assign mLane[li] = opM[li*LANE_W +: LANE_W];
    assign mSel      = strobes.crossM ? mLane[OTHER] : mLane[li];
    assign laneSub   = (li == 0) ? strobes.subLo : strobes.subHi;

    dhsat_lane #(.LANE_W(LANE_W)) u_lane (
      .laneA (nLane[li]),
      .laneB (mSel),
      .doSub (laneSub),
      .laneY (outLane[li])
    );

    assign packedNext[li*LANE_W +: LANE_W] = outLane[li];
  end

  always_ff @(posedge clk) begin
    if (rst) result <= '0;
    else     result <= packedNext;
  end
endmodule

// File: rtl/dhsat_unit.sv
`timescale 1ns/1ps
module dhsat_unit
  import dhsat_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int INSTR_W = 32,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] instr,
  input  logic [DATA_W-1:0]  opN,
  input  logic [DATA_W-1:0]  opM,
  input  logic [3:0]         flags,
  output logic [IDX_W-1:0]   srcNIdx,
  output logic [IDX_W-1:0]   srcMIdx,
  output logic [IDX_W-1:0]   dstIdx,
  output logic [DATA_W-1:0]  result,
  output logic               wrEn,
  output logic               undefOp
);
  laneCtrl_t strobes;

  dhsat_ctrl #(.INSTR_W(INSTR_W), .IDX_W(IDX_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .instr   (instr),
    .flags   (flags),
    .strobes (strobes),
    .srcNIdx (srcNIdx),
    .srcMIdx (srcMIdx),
    .dstIdx  (dstIdx),
    .wrEn    (wrEn),
    .undefOp (undefOp)
  );

  dhsat_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .opN     (opN),
    .opM     (opM),
    .strobes (strobes),
    .result  (result)
  );
endmodule

// File: rtl/dhsat_chk.sv
`timescale 1ns/1ps
module dhsat_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] instr,
  input logic [31:0] opN,
  input logic [31:0] opM,
  input logic [3:0]  dstIdx,
  input logic [31:0] result,
  input logic        wrEn,
  input logic        undefOp
);
  // R9
  excl_wr_undef_chk: assert property (@(posedge clk) disable iff (rst)
    !(wrEn && undefOp));

  // R10
  dst_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (dstIdx == $past(instr[15:12])));

  // R7
  always_exec_chk: assert property (@(posedge clk) disable iff (rst)
    (instr[31:28] == 4'hE && instr[27:20] == 8'h62 && instr[11:8] == 4'hF &&
     instr[4] && !instr[7]) |=> wrEn);

  // R7
  never_exec_chk: assert property (@(posedge clk) disable iff (rst)
    (instr[31:28] == 4'hF) |=> !wrEn);

  // R9
  bad_sel_chk: assert property (@(posedge clk) disable iff (rst)
    instr[7] |=> undefOp);

  // R4
  self_sub_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (instr[7:5] == 3'd3 && opN == opM) |=> (result == 32'h0));
endmodule

bind dhsat_unit dhsat_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .instr   (instr),
  .opN     (opN),
  .opM     (opM),
  .dstIdx  (dstIdx),
  .result  (result),
  .wrEn    (wrEn),
  .undefOp (undefOp)
);

// File: tb/tb_dhsat_unit.sv
`timescale 1ns/1ps
module tb_dhsat_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] instr, opN, opM;
  logic [3:0]  flags;
  logic [3:0]  srcNIdx, srcMIdx, dstIdx;
  logic [31:0] result;
  logic        wrEn, undefOp;

  int errCnt = 0;
  int chkCnt = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dhsat_unit dut (
    .clk(clk), .rst(rst), .instr(instr), .opN(opN), .opM(opM), .flags(flags),
    .srcNIdx(srcNIdx), .srcMIdx(srcMIdx), .dstIdx(dstIdx), .result(result),
    .wrEn(wrEn), .undefOp(undefOp)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    chkCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [3:0] cc, input logic [2:0] sel,
                                     input logic [3:0] rd, input logic [3:0] rn,
                                     input logic [3:0] rm);
    return {cc, 8'h62, rn, rd, 4'hF, sel, 1'b1, rm};
  endfunction

  function automatic logic [15:0] pick(input int k);
    case (k)
      0: return 16'h0000; 1: return 16'h0001; 2: return 16'h7FFF;
      3: return 16'h8000; 4: return 16'hFFFF; 5: return 16'h4000;
      6: return 16'hC000; default: return 16'h8001;
    endcase
  endfunction

  function automatic logic [15:0] ref16(input logic [15:0] a, input logic [15:0] b,
                                       input bit sub);
    int r;
    r = sub ? (int'($signed(a)) - int'($signed(b))) : (int'($signed(a)) + int'($signed(b)));
    if (r > 32767) r = 32767;
    else if (r < -32768) r = -32768;
    return r[15:0];
  endfunction

  function automatic bit refCond(input logic [3:0] cc, input logic [3:0] f);
    bit n, z, c, v;
    {n, z, c, v} = f;
    case (cc)
      0: return z;            1: return !z;
      2: return c;            3: return !c;
      4: return n;            5: return !n;
      6: return v;            7: return !v;
      8: return c && !z;      9: return !c || z;
      10: return n == v;      11: return n != v;
      12: return !z && n == v; 13: return z || n != v;
      14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic apply(input logic [31:0] i, input logic [31:0] a, input logic [31:0] b,
                       input logic [3:0] f);
    @(negedge clk);
    instr = i; opN = a; opM = b; flags = f;
    @(posedge clk);
    #2;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errCnt++;
      chkCnt++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; instr = mk(4'hE, 3'd0, 4'd5, 4'd1, 4'd2);
    opN = 32'h7FFF7FFF; opM = 32'h00010001; flags = 4'h0;
    repeat (3) @(posedge clk);
    #2;
    // R11 reset state
    check(result == 0 && !wrEn && !undefOp && dstIdx == 0, "R11",
          {result[27:0], dstIdx}, 32'h0);
    @(negedge clk); rst = 1'b0;

    // R12 combinational source indices
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      instr = mk(4'hE, 3'd0, 4'd0, 4'(k), 4'(15 - k));
      #1;
      check(srcNIdx == 4'(k) && srcMIdx == 4'(15 - k), "R12",
            {24'h0, srcNIdx, srcMIdx}, {24'h0, 4'(k), 4'(15 - k)});
    end

    // R6 packing
    apply(mk(4'hE, 3'd0, 4'd1, 4'd2, 4'd3), 32'h00020001, 32'h00200010, 4'h0);
    check(result == 32'h00220011, "R6", result, 32'h00220011);

    // R5 clamp ends, lanes independent
    apply(mk(4'hE, 3'd0, 4'd1, 4'd2, 4'd3), 32'h80007FFF, 32'hFFFF0001, 4'h0);
    check(result == 32'h80007FFF, "R5", result, 32'h80007FFF);
    apply(mk(4'hE, 3'd3, 4'd1, 4'd2, 4'd3), 32'h7FFF8000, 32'hFFFF0001, 4'h0);
    check(result == 32'h7FFF8000, "R5", result, 32'h7FFF8000);

    // R1..R4 sweep over boundary halfwords
    for (int op = 0; op < 4; op++)
      for (int a = 0; a < 8; a++)
        for (int b = 0; b < 8; b++)
          for (int c = 0; c < 8; c++)
            for (int d = 0; d < 8; d++) begin
              logic [31:0] n, m, e;
              logic [15:0] eLo, eHi;
              string tag;
              n = {pick(b), pick(a)};
              m = {pick(d), pick(c)};
              case (op)
                0: begin eLo = ref16(n[15:0], m[15:0], 0);  eHi = ref16(n[31:16], m[31:16], 0); tag = "R1"; end
                1: begin eLo = ref16(n[15:0], m[31:16], 1); eHi = ref16(n[31:16], m[15:0], 0);  tag = "R2"; end
                2: begin eLo = ref16(n[15:0], m[31:16], 0); eHi = ref16(n[31:16], m[15:0], 1);  tag = "R3"; end
                default: begin eLo = ref16(n[15:0], m[15:0], 1); eHi = ref16(n[31:16], m[31:16], 1); tag = "R4"; end
              endcase
              e = {eHi, eLo};
              apply(mk(4'hE, 3'(op), 4'd7, 4'd1, 4'd2), n, m, 4'h0);
              check(result == e && wrEn && !undefOp, tag, result, e);
            end

    // R7 / R8 condition table
    for (int cc = 0; cc < 16; cc++)
      for (int f = 0; f < 16; f++) begin
        bit p;
        p = refCond(4'(cc), 4'(f));
        apply(mk(4'(cc), 3'd0, 4'd3, 4'd1, 4'd2), 32'h1, 32'h1, 4'(f));
        check(wrEn == p, "R7", {31'h0, wrEn}, {31'h0, p});
        check(!undefOp, "R8", {31'h0, undefOp}, 32'h0);
      end

    // R9 unsupported selectors and bad fixed bits
    for (int s = 4; s < 8; s++) begin
      apply(mk(4'hE, 3'(s), 4'd3, 4'd1, 4'd2), 32'h5, 32'h6, 4'h0);
      check(undefOp && !wrEn, "R9", {30'h0, undefOp, wrEn}, 32'h2);
    end
    apply(mk(4'hE, 3'd0, 4'd3, 4'd1, 4'd2) & ~32'h10, 32'h5, 32'h6, 4'h0);
    check(undefOp && !wrEn, "R9", {30'h0, undefOp, wrEn}, 32'h2);
    apply(mk(4'hE, 3'd0, 4'd3, 4'd1, 4'd2) & ~32'h100, 32'h5, 32'h6, 4'h0);
    check(undefOp && !wrEn, "R9", {30'h0, undefOp, wrEn}, 32'h2);
    apply({4'hE, 8'h61, 20'h03F12}, 32'h5, 32'h6, 4'h0);
    check(undefOp && !wrEn, "R9", {30'h0, undefOp, wrEn}, 32'h2);

    // R10 destination index, one-cycle latency
    for (int rd = 0; rd < 16; rd++) begin
      apply(mk(4'hE, 3'd0, 4'(rd), 4'd1, 4'd2), 32'(rd), 32'h0, 4'h0);
      check(dstIdx == 4'(rd) && result == 32'(rd), "R10", {dstIdx, result[27:0]},
            {4'(rd), 28'(rd)});
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end
endmodule